// File: doc/BRIEF.md
# Three-Phase Dead-Time Inserter

This block sits between a motor-control PWM generator and the gate drivers of three half-bridges. For each phase it takes a high-side command and a low-side command. It produces registered enables for the high-side and low-side gates. It guarantees that one switch of a phase has been off for a programmable number of clock cycles before its complementary switch turns on.

The programmed gap is a floor, not an addition. A controller that already leaves a long enough pause sees its edges pass with only the one register stage of latency. The block also:
- holds a freshly enabled gate on for a minimum pulse;
- refuses to drive both switches of a phase together;
- obeys a global force-off input from the protection logic, which overrides everything else.

Every input is a plain level sampled on the clock, with no handshake. Every output is a plain level driven straight from a register.

Top module: `deadband_gen3`

## Requirements
- R1: After a gate of a phase turns off, the complementary gate of that phase turns on only when both gates of the phase have been low for at least D cycles. When the commands swap sides directly, the low gap is exactly D cycles.
- R2: D is the larger of the value on `dt_cycles` and the floor MIN_DT (default 5 cycles). A setting of 0 or 3 therefore yields a 5-cycle gap.
- R3: The gap is a minimum only. When the both-off interval has already lasted D cycles, a gate rises one clock after its command is sampled.
- R4: A gate that turns on stays on for at least MIN_ON cycles (default 5), even if its command is a single cycle long.
- R5: Both gates of a phase are never high together. While both commands of a phase are high, that phase raises neither gate.
- R6: While `force_off` is sampled high, all six gates are low from the next clock. This also cuts short the minimum on-pulse.
- R7: After `force_off` is released, every gate stays low for D cycles before it may turn on.
- R8: A command that changes while its phase is still waiting out the gap restarts the decision from the new command. The gap is still counted from the original turn-off, and the abandoned side never produces a pulse.
- R9: All three phases have identical cycle timing: the same stimulus gives the same output waveform on every phase.
- R10: During reset all gates are low. After reset ends, a gate waits D cycles before its first turn-on, and a gate rises only when its own command is high alone and `force_off` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all timing is counted in its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| dt_cycles | input | DTW | Requested dead time in cycles, raised to MIN_DT when below it |
| force_off | input | 1 | Protection kill; all gates low while high |
| cmd_hi | input | NPH | High-side commands, bit i for phase i |
| cmd_lo | input | NPH | Low-side commands, bit i for phase i |
| gate_hi | output | NPH | Registered high-side gate enables |
| gate_lo | output | NPH | Registered low-side gate enables |

## Verification
Every phase is swept against dead-time settings below, at and above the floor. The runs use these command patterns:
- A direct side swap. The measured low gap must equal D exactly, which separates a correct floor and clamp from an off-by-one or an unclamped count.
- A command arriving after a long pause. It must pass with one cycle of latency, which tells a minimum-gap design apart from one that adds the delay.
- A short controller pause. It must be stretched to exactly D.
- A swap that is abandoned mid-gap. It shows whether the gap is counted from the real turn-off and whether the abandoned side glitches.

Single-cycle pulses, overlapping commands and a force-off pulse (including one that lands inside a minimum on-pulse) exercise the pulse floor, the overlap lockout and the recovery delay. An identical pattern driven on all three phases at once must give matching outputs.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

  // State of one half-bridge leg pair
  typedef enum logic [1:0] {
    LEG_OFF = 2'd0,
    LEG_HI  = 2'd1,
    LEG_LO  = 2'd2
  } leg_e;

endpackage

// File: rtl/dbg_delay_clamp.sv
module dbg_delay_clamp #(
  parameter int DTW    = 8,
  parameter int MIN_DT = 5
) (
  input  logic [DTW-1:0] dt_req,
  output logic [DTW-1:0] dt_eff
);
  localparam logic [DTW-1:0] FLOOR = DTW'(MIN_DT);

  always_comb begin
    dt_eff = (dt_req < FLOOR) ? FLOOR : dt_req;
  end
endmodule

// File: rtl/dbg_phase_ctl.sv
module dbg_phase_ctl
  import dbg_pkg::*;
#(
  parameter int DTW    = 8,
  parameter int MIN_ON = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_hi,
  input  logic           req_lo,
  input  logic           kill,
  input  logic [DTW-1:0] dt_eff,
  output logic           out_hi,
  output logic           out_lo
);
  localparam int ONW = $clog2(MIN_ON + 2);
  localparam logic [ONW-1:0] ON_FLOOR = ONW'(MIN_ON);
  localparam logic [ONW-1:0] ON_MAX   = '1;
  localparam logic [DTW-1:0] GAP_MAX  = '1;

  leg_e           st;
  logic [DTW-1:0] gap;     // cycles both gates have been low
  logic [ONW-1:0] on_cnt;  // cycles the active gate has been high

  logic only_hi, only_lo, gap_ok;
  assign only_hi = req_hi & ~req_lo;
  assign only_lo = req_lo & ~req_hi;
  assign gap_ok  = (gap >= dt_eff);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= LEG_OFF;
      gap    <= '0;
      on_cnt <= '0;
    end else if (kill) begin
      st     <= LEG_OFF;
      gap    <= '0;
      on_cnt <= '0;
    end else begin
      unique case (st)
        LEG_OFF: begin
          if (gap_ok && only_hi) begin
            st     <= LEG_HI;
            on_cnt <= ONW'(1);
          end else if (gap_ok && only_lo) begin
            st     <= LEG_LO;
            on_cnt <= ONW'(1);
          end else if (gap != GAP_MAX) begin
            gap <= gap + 1'b1;
          end
        end
        LEG_HI: begin
          if (!only_hi && on_cnt >= ON_FLOOR) begin
            st     <= LEG_OFF;
            gap    <= DTW'(1);
            on_cnt <= '0;
          end else if (on_cnt != ON_MAX) begin
            on_cnt <= on_cnt + 1'b1;
          end
        end
        LEG_LO: begin
          if (!only_lo && on_cnt >= ON_FLOOR) begin
            st     <= LEG_OFF;
            gap    <= DTW'(1);
            on_cnt <= '0;
          end else if (on_cnt != ON_MAX) begin
            on_cnt <= on_cnt + 1'b1;
          end
        end
        default: begin
          st <= LEG_OFF;
        end
      endcase
    end
  end

  assign out_hi = (st == LEG_HI);
  assign out_lo = (st == LEG_LO);
endmodule

// File: rtl/deadband_gen3.sv
module deadband_gen3 #(
  parameter int NPH    = 3,
  parameter int DTW    = 8,
  parameter int MIN_DT = 5,
  parameter int MIN_ON = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [DTW-1:0] dt_cycles,
  input  logic           force_off,
  input  logic [NPH-1:0] cmd_hi,
  input  logic [NPH-1:0] cmd_lo,
  output logic [NPH-1:0] gate_hi,
  output logic [NPH-1:0] gate_lo
);
  logic [DTW-1:0] dt_eff;

  dbg_delay_clamp #(.DTW(DTW), .MIN_DT(MIN_DT)) u_clamp (
    .dt_req(dt_cycles),
    .dt_eff(dt_eff)
  );

  for (genvar g = 0; g < NPH; g++) begin : g_phase
    dbg_phase_ctl #(.DTW(DTW), .MIN_ON(MIN_ON)) u_leg (
      .clk   (clk),
      .rst_n (rst_n),
      .req_hi(cmd_hi[g]),
      .req_lo(cmd_lo[g]),
      .kill  (force_off),
      .dt_eff(dt_eff),
      .out_hi(gate_hi[g]),
      .out_lo(gate_lo[g])
    );
  end
endmodule

// File: rtl/deadband_gen3_chk.sv
module deadband_gen3_chk #(
  parameter int NPH    = 3,
  parameter int DTW    = 8,
  parameter int MIN_DT = 5,
  parameter int MIN_ON = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic [DTW-1:0] dt_cycles,
  input logic           force_off,
  input logic [NPH-1:0] cmd_hi,
  input logic [NPH-1:0] cmd_lo,
  input logic [NPH-1:0] gate_hi,
  input logic [NPH-1:0] gate_lo
);
  logic [DTW-1:0] need;
  assign need = (dt_cycles < DTW'(MIN_DT)) ? DTW'(MIN_DT) : dt_cycles;

  // R6
  force_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |=> (gate_hi == '0 && gate_lo == '0));

  for (genvar g = 0; g < NPH; g++) begin : g_chk
    logic [DTW-1:0] off_run;
    logic [7:0]     hi_run;

    always_ff @(posedge clk) begin
      if (!rst_n || force_off) off_run <= '0;
      else if (gate_hi[g] || gate_lo[g]) off_run <= '0;
      else if (off_run != '1) off_run <= off_run + 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rst_n || !gate_hi[g]) hi_run <= '0;
      else if (hi_run != 8'hff) hi_run <= hi_run + 1'b1;
    end

    // R5
    no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_hi[g] && gate_lo[g]));

    // R1
    gap_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((gate_hi[g] || gate_lo[g]) && $past(!gate_hi[g] && !gate_lo[g]))
      |-> (off_run >= $past(need)));

    // R4
    min_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(gate_hi[g]) && !$past(force_off)) |-> (hi_run >= 8'(MIN_ON)));

    // R10
    turn_on_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_hi[g]) |-> $past(cmd_hi[g] && !cmd_lo[g] && !force_off));
  end
endmodule

bind deadband_gen3 deadband_gen3_chk #(
  .NPH(NPH), .DTW(DTW), .MIN_DT(MIN_DT), .MIN_ON(MIN_ON)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dt_cycles(dt_cycles), .force_off(force_off),
  .cmd_hi(cmd_hi), .cmd_lo(cmd_lo), .gate_hi(gate_hi), .gate_lo(gate_lo)
);

// File: tb/deadband_gen3_test.sv
module deadband_gen3_test;
  localparam int CLK_NS = 10;
  localparam int NPH    = 3;
  localparam int DTW    = 8;
  localparam int MIN_DT = 5;
  localparam int MIN_ON = 5;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [DTW-1:0] dt_cycles = '0;
  logic           force_off = 1'b0;
  logic [NPH-1:0] cmd_hi = '0;
  logic [NPH-1:0] cmd_lo = '0;
  logic [NPH-1:0] gate_hi, gate_lo;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  deadband_gen3 #(.NPH(NPH), .DTW(DTW), .MIN_DT(MIN_DT), .MIN_ON(MIN_ON)) uut (
    .clk(clk), .rst_n(rst_n), .dt_cycles(dt_cycles), .force_off(force_off),
    .cmd_hi(cmd_hi), .cmd_lo(cmd_lo), .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic test_phase(input int p, input int dt);
    int d;
    int n;
    bit seen;
    d = (dt < MIN_DT) ? MIN_DT : dt;
    cmd_hi = '0; cmd_lo = '0; force_off = 0; dt_cycles = DTW'(dt);
    repeat (40) step();

    // R3: long idle, rise after one clock
    cmd_hi[p] = 1; step();
    chk(gate_hi[p] == 1'b1, "R3 idle rise", int'(gate_hi[p]), 1);
    repeat (8) step();

    // R1 R2: direct swap hi -> lo, gap exactly D
    cmd_hi[p] = 0; cmd_lo[p] = 1; n = 0;
    step();
    while (!gate_lo[p] && n < 200) begin n++; step(); end
    chk(n == d, "R1 R2 swap gap", n, d);
    repeat (8) step();

    // R3: controller already left D+1 idle cycles
    cmd_lo[p] = 0; repeat (d + 2) step();
    cmd_hi[p] = 1; step();
    chk(gate_hi[p] == 1'b1, "R3 no extra delay", int'(gate_hi[p]), 1);
    repeat (8) step();

    // R1: short controller gap of 2 stretched to D
    cmd_hi[p] = 0; step(); step();
    cmd_lo[p] = 1; n = 2; step();
    while (!gate_lo[p] && n < 200) begin n++; step(); end
    chk(n == d, "R1 short gap stretched", n, d);
    repeat (8) step();

    // R8: swap abandoned mid-gap
    cmd_lo[p] = 0; cmd_hi[p] = 1; n = 0; seen = 0;
    repeat (2) begin
      step();
      if (gate_hi[p]) seen = 1;
      if (!gate_lo[p]) n++;
    end
    cmd_hi[p] = 0; cmd_lo[p] = 1;
    step();
    while (!gate_lo[p] && n < 200) begin
      if (gate_hi[p]) seen = 1;
      n++; step();
    end
    chk(seen == 0, "R8 no glitch on abandoned side", int'(seen), 0);
    chk(n == d, "R8 gap from first turn-off", n, d);
    repeat (8) step();

    // R4: single-cycle command gives MIN_ON pulse
    cmd_lo[p] = 0; repeat (d + 2) step();
    cmd_hi[p] = 1; step();
    cmd_hi[p] = 0; n = 0;
    while (gate_hi[p] && n < 200) begin n++; step(); end
    chk(n == MIN_ON, "R4 min on pulse", n, MIN_ON);

    // R5: both commands high -> both gates held low
    repeat (d + 2) step();
    cmd_hi[p] = 1; cmd_lo[p] = 1; seen = 0;
    repeat (10) begin
      step();
      if (gate_hi[p] || gate_lo[p]) seen = 1;
    end
    chk(seen == 0, "R5 overlap lockout", int'(seen), 0);
    cmd_lo[p] = 0; step();
    chk(gate_hi[p] == 1'b1, "R5 release to single side", int'(gate_hi[p]), 1);

    // R6: force-off during min-on pulse
    force_off = 1; step();
    chk(gate_hi == '0 && gate_lo == '0, "R6 force off", int'({gate_hi, gate_lo}), 0);
    repeat (3) step();

    // R7: recovery wait after release
    force_off = 0; n = 0; step();
    while (!gate_hi[p] && n < 200) begin n++; step(); end
    chk(n == d, "R7 recovery gap", n, d);
    cmd_hi = '0; cmd_lo = '0;
    repeat (10) step();
  endtask

  initial begin : watchdog
    #(CLK_NS * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog R1..: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int n;
    bit same;
    dt_cycles = '0;
    repeat (3) step();
    // R10: reset state
    chk(gate_hi == '0 && gate_lo == '0, "R10 reset low", int'({gate_hi, gate_lo}), 0);
    // R10: first turn-on waits D after reset
    rst_n = 1; cmd_hi[0] = 1; n = 0; step();
    while (!gate_hi[0] && n < 200) begin n++; step(); end
    chk(n == MIN_DT, "R10 wait after reset", n, MIN_DT);
    cmd_hi = '0; repeat (10) step();

    foreach (cmd_hi[p]) begin
      test_phase(p, 0);
      test_phase(p, 3);
      test_phase(p, 5);
      test_phase(p, 6);
      test_phase(p, 12);
    end

    // R9: identical pattern on all phases gives identical waveforms
    dt_cycles = DTW'(7); same = 1;
    repeat (20) step();
    for (int k = 0; k < 60; k++) begin
      cmd_hi = (k % 20 < 9) ? '1 : '0;
      cmd_lo = (k % 20 >= 11) ? '1 : '0;
      step();
      if (gate_hi != {NPH{gate_hi[0]}} || gate_lo != {NPH{gate_lo[0]}}) same = 0;
    end
    chk(same == 1, "R9 phases match", int'(same), 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule